// File: doc/BRIEF.md
# Rate Divider with Square-Wave and Periodic Flag

This block divides a 32.768 kHz time-base enable through a 15-stage binary chain. A three-bit mode field starts the chain, clears it, or freezes it. A four-bit rate code picks one point of the chain, or none.

The chosen point drives two outputs. One is a square-wave pin, gated by its own enable. The other is a periodic flag that is set once per selected period. The flag raises an interrupt request only while the interrupt enable is on. Software clears the flag with a one-cycle strobe, issued when the status register is read.

A one-cycle tick marks each full wrap of the chain, once per second, and feeds the calendar update logic.

Top module: `rate_divider`

## Requirements
- R1: While `rst_n` is low, the chain is zero and `sqw_out`, `pf`, `irq` and `sec_tick` are all 0.
- R2: With `mode` = 3'b010, the chain advances by one on each clock edge where `tb_en` is 1. It holds when `tb_en` is 0.
- R3: With `mode[2:1]` = 2'b11, the chain is cleared to zero at every clock edge.
- R4: Any `mode` other than 3'b010 and 3'b11x freezes the chain at its current count.
- R5: `rate` selects the exponent e as follows: codes 3 to 15 give e equal to the code, code 1 gives e = 8 and code 2 gives e = 9. The period is 2^(e-1) counts, and `sqw_out` follows chain bit e-2, which toggles every half period.
- R6: With `rate` = 0, `sqw_out` is 0 and `pf` is never set.
- R7: With `sqw_en` = 0, `sqw_out` is 0.
- R8: `pf` is set at the edge where the chain advances from a count whose low e-1 bits are all ones. This happens whatever the value of `pie_en`.
- R9: `irq` is 1 exactly when both `pf` and `pie_en` are 1.
- R10: `flag_clr` clears `pf` at the next edge. A set event at that same edge wins over the clear.
- R11: `sec_tick` is 1 for exactly one cycle, after the edge at which the chain advances from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_en | input | 1 | 32.768 kHz time-base enable, one cycle wide |
| mode | input | 3 | Chain control: 010 runs, 11x clears, others freeze |
| rate | input | 4 | Tap select, 0 turns the tap off |
| pie_en | input | 1 | Interrupt enable for the periodic flag |
| sqw_en | input | 1 | Square-wave output enable |
| flag_clr | input | 1 | Clear strobe for the periodic flag |
| sqw_out | output | 1 | Square-wave level |
| pf | output | 1 | Periodic flag |
| irq | output | 1 | Interrupt request |
| sec_tick | output | 1 | One-cycle pulse per chain wrap |

## Verification
`sqw_out` and `irq` are combinational from the chain, the flag and the present enables. They are due in the same cycle the inputs change. `pf`, `sec_tick` and the chain all change at the first rising edge after the stimulus.

The bench drives inputs just after a falling edge and compares the outputs 1 ns later. At that point it checks them against a model state that reflects every edge seen so far. It then steps the model once, for the edge that follows.

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int STAGES = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_en,
  input  logic [2:0] mode,
  input  logic [3:0] rate,
  input  logic       pie_en,
  input  logic       sqw_en,
  input  logic       flag_clr,
  output logic       sqw_out,
  output logic       pf,
  output logic       irq,
  output logic       sec_tick
);
  localparam logic [STAGES-1:0] ONES = {STAGES{1'b1}};

  logic [STAGES-1:0] cnt;
  logic [4:0]        tap_exp;
  logic [STAGES-1:0] mask;

  wire run       = (mode == 3'b010);
  wire clr_chain = (mode[2:1] == 2'b11);
  wire adv       = run && tb_en;

  always_comb begin
    case (rate)
      4'd0:    tap_exp = 5'd0;
      4'd1:    tap_exp = 5'd8;
      4'd2:    tap_exp = 5'd9;
      default: tap_exp = {1'b0, rate};
    endcase
  end

  assign mask = ~(ONES << (tap_exp - 5'd1));

  wire tap_on     = (tap_exp != 5'd0);
  wire tap_bit    = |(cnt & (mask ^ (mask >> 1)));
  wire period_end = adv && tap_on && ((cnt & mask) == mask);
  wire wrap       = adv && (cnt == ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pf       <= 1'b0;
      sec_tick <= 1'b0;
    end else begin
      if (clr_chain)  cnt <= '0;
      else if (adv)   cnt <= cnt + 1'b1;
      if (period_end) pf <= 1'b1;
      else if (flag_clr) pf <= 1'b0;
      sec_tick <= wrap;
    end
  end

  assign sqw_out = sqw_en && tap_on && tap_bit;
  assign irq     = pf && pie_en;
endmodule

module rate_divider_chk #(
  parameter int STAGES = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic [3:0]        rate,
  input logic              flag_clr,
  input logic              pf,
  input logic              sec_tick,
  input logic [STAGES-1:0] cnt
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0; else seen <= 1'b1;

  AST_CHAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(mode[2:1]) == 2'b11 |-> cnt == '0);                                // R3
  AST_CHAIN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(mode) != 3'b010 && $past(mode[2:1]) != 2'b11 |-> $stable(cnt));   // R4
  AST_NO_RATE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $rose(pf) |-> $past(rate) != 4'd0);                                       // R6
  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $fell(pf) |-> $past(flag_clr));                                           // R10
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);                                                          // R11
endmodule

bind rate_divider rate_divider_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rate(rate), .flag_clr(flag_clr),
  .pf(pf), .sec_tick(sec_tick), .cnt(cnt)
);

// File: tb/tb_rate_divider.sv
module tb_rate_divider;
  logic clk = 1'b0, rst_n = 1'b0, tb_en = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [3:0] rate = 4'd0;
  logic pie_en = 1'b0, sqw_en = 1'b0, flag_clr = 1'b0;
  logic sqw_out, pf, irq, sec_tick;

  int checks = 0, errors = 0;
  int mcnt = 0;
  bit mpf = 0, msec = 0;

  always #4 clk = ~clk;

  rate_divider dut (.*);

  function automatic int exp_of(logic [3:0] r);
    if (r == 0) return 0;
    if (r == 1) return 8;
    if (r == 2) return 9;
    return int'(r);
  endfunction

  function automatic bit exp_sqw();
    int e = exp_of(rate);
    if (!sqw_en || e == 0) return 0;
    return ((mcnt >> (e - 2)) & 1) != 0;
  endfunction

  task automatic chk(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic cyc(string tag);
    int e;
    bit pe, wr;
    #1;
    chk({tag, "/R5 sqw"}, sqw_out, exp_sqw());
    chk({tag, "/R8 pf"}, pf, mpf);
    chk({tag, "/R9 irq"}, irq, mpf && pie_en);
    chk({tag, "/R11 tick"}, sec_tick, msec);
    e = exp_of(rate);
    pe = 0; wr = 0;
    if (rst_n) begin
      if (mode == 3'b010 && tb_en) begin
        pe = (e != 0) && ((mcnt % (1 << (e - 1))) == (1 << (e - 1)) - 1);
        wr = (mcnt == 32767);
        mcnt = (mcnt + 1) % 32768;
      end else if (mode[2:1] == 2'b11) mcnt = 0;
      mpf = pe ? 1'b1 : (flag_clr ? 1'b0 : mpf);
      msec = wr;
    end
    @(negedge clk);
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk);
    // R1 reset state
    mode = 3'b010; tb_en = 1; rate = 4'd3; sqw_en = 1; pie_en = 1;
    repeat (4) cyc("R1");
    rst_n = 1;
    // R2 run, R5 fast tap
    repeat (40) cyc("R2");
    tb_en = 0; repeat (5) cyc("R2 hold");
    // R4 freeze
    tb_en = 1; mode = 3'b000; repeat (10) cyc("R4");
    mode = 3'b101; repeat (10) cyc("R4");
    // R3 clear
    mode = 3'b111; repeat (3) cyc("R3");
    mode = 3'b110; repeat (3) cyc("R3");
    // R6 rate off
    mode = 3'b010; rate = 4'd0; flag_clr = 1; cyc("R6"); flag_clr = 0;
    repeat (300) cyc("R6");
    // R7 square-wave disabled
    rate = 4'd3; sqw_en = 0; repeat (20) cyc("R7");
    // R8 flag with interrupt off, R10 clear and collision
    sqw_en = 1; pie_en = 0; repeat (8) cyc("R8");
    pie_en = 1; flag_clr = 1; cyc("R10"); flag_clr = 0;
    repeat (2) cyc("R10");
    flag_clr = 1; repeat (4) cyc("R10 set-wins"); flag_clr = 0;
    // R11 full wrap
    mode = 3'b110; cyc("R3"); mode = 3'b010; rate = 4'd15;
    repeat (33000) cyc("R11");
    // random segments
    for (int s = 0; s < 40; s++) begin
      rate = 4'($urandom_range(0, 15));
      sqw_en = 1'($urandom); pie_en = 1'($urandom);
      for (int i = 0; i < 2500; i++) begin
        tb_en = ($urandom_range(0, 3) != 0);
        flag_clr = ($urandom_range(0, 15) == 0);
        mode = ($urandom_range(0, 63) == 0) ? 3'($urandom) : 3'b010;
        cyc("rand");
      end
    end
    flag_clr = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule